// File: doc/BRIEF.md
# Flash Completion Status Poller

This block runs on the host side of a parallel NOR flash. It waits for an internal program or erase inside the flash to finish. Command issue is handled elsewhere. Once the last write of a command sequence has gone out, the controller sends a start pulse. The pulse carries three things: the operation kind (program or erase), the byte that was written, and the detection method. The poller then drives a stream of read requests to an external bus driver, one at a time. It inspects each returned status byte and decides whether the flash is still busy.

Two detection methods are available.

- **Inverted-data method.** During a program, bit 7 reads back as the complement of the written bit 7. During an erase, bit 7 reads back as 0. Completion is seen when bit 7 shows its final value. One more read then fetches the full byte, and that byte is compared against the expected value.
- **Toggle method.** Bit 6 alternates on every read while the flash is busy. Completion is seen when two consecutive reads agree on bit 6.

A run-time cycle limit aborts a wait that never finishes. The poller reports the outcome through a one-cycle done pulse, a timeout flag and a mismatch flag.

The start pulse may only be given after the final write of the command: the 4th write for a program and the 6th for an erase. No read goes out before a start is accepted.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, busy_o, rd_req_o, done_o, timeout_o and mismatch_o are all low.
- R2: A start_i pulse seen while idle makes busy_o high in the next cycle, and rd_req_o is high in that same cycle. rd_req_o is never high while busy_o is low.
- R3: Only one read is outstanding at a time. rd_req_o is high for one cycle, and the next request is raised in the cycle right after rd_valid_i returns data.
- R4: In inverted-data mode (mode_toggle_i=0) for a program (op_erase_i=0), polling continues while rd_data_i[7] differs from exp_data_i[7]. It completes on the first read where they match.
- R5: In inverted-data mode for an erase (op_erase_i=1), a read with rd_data_i[7]=0 means busy and a read with bit 7 = 1 means complete, whatever exp_data_i[7] is.
- R6: In inverted-data mode, after bit 7 shows completion one extra read is made. If that full byte differs from exp_data_i, mismatch_o is set in the same cycle as done_o.
- R7: In toggle mode (mode_toggle_i=1), completion is two consecutive reads with equal rd_data_i[6]. The first read of an operation never completes it, and mismatch_o stays low.
- R8: done_o is a one-cycle pulse, and busy_o is low in the cycle it is high.
- R9: With timeout_cycles_i = N > 0, an operation that has not completed after N busy cycles returns to idle with timeout_o high and no done_o. N = 0 disables the limit.
- R10: A start_i pulse while busy is ignored. Operation kind, expected byte and mode stay as latched at the accepted start.
- R11: If the completing read arrives in the very cycle the limit expires, completion wins: done_o pulses and timeout_o stays low.
- R12: timeout_o and mismatch_o hold until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| mode_toggle_i | input | 1 | 1 = toggle method, 0 = inverted-data method |
| exp_data_i | input | DW | Byte written (expected final data) |
| timeout_cycles_i | input | TW | Busy-cycle limit, 0 = no limit |
| rd_req_o | output | 1 | One-cycle read request to the bus driver |
| rd_valid_i | input | 1 | Read data strobe |
| rd_data_i | input | DW | Status byte returned by the read |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Sticky timeout flag |
| mismatch_o | output | 1 | Sticky verify-mismatch flag |

## Verification
Completion and timeout expiry can fall in the same cycle. The bench provokes this with a toggle-mode run whose second read, the completing one, lands in busy cycle 4.

- With a limit of 4, the expected result is a done pulse with no timeout.
- With a limit of 3, the expected result is a timeout after exactly three busy cycles, with no done pulse.

A start pulse arriving mid-poll is also injected. It carries a different expected byte, and the bench judges it by an unchanged read count and a clean verify.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_VREQ,
    ST_VWAIT
  } fsp_state_e;
endpackage

// File: rtl/fsp_timer.sv
module fsp_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (run_i && cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // busy cycle k sees cnt_q = k-1
  assign expire_o = run_i && (limit_i != '0) && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/fsp_decider.sv
module fsp_decider #(
  parameter int unsigned DW      = 8,
  parameter int unsigned POLL_B  = 7,
  parameter int unsigned TOGG_B  = 6
) (
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] exp_i,
  input  logic          erase_i,
  input  logic          toggle_i,
  input  logic          prev_vld_i,
  input  logic          prev_bit_i,
  output logic          poll_done_o,
  output logic          diff_o
);
  logic bar_done;
  logic tog_done;

  assign bar_done    = erase_i ? data_i[POLL_B] : (data_i[POLL_B] == exp_i[POLL_B]);
  assign tog_done    = prev_vld_i && (data_i[TOGG_B] == prev_bit_i);
  assign poll_done_o = toggle_i ? tog_done : bar_done;
  assign diff_o      = (data_i != exp_i);
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import fsp_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned TW     = 16,
  parameter int unsigned POLL_B = 7,
  parameter int unsigned TOGG_B = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic          mode_toggle_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic [TW-1:0] timeout_cycles_i,
  output logic          rd_req_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic          mismatch_o
);
  fsp_state_e    state_q, state_d;
  logic [DW-1:0] exp_q;
  logic [TW-1:0] lim_q;
  logic          erase_q, toggle_q;
  logic          prev_vld_q, prev_bit_q;
  logic          done_q, to_q, mis_q;

  logic accept, expire, poll_done, diff;
  logic finish, abort, set_mis, upd_prev;

  assign accept = (state_q == ST_IDLE) && start_i;

  fsp_timer #(.TW(TW)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .run_i    (state_q != ST_IDLE),
    .limit_i  (lim_q),
    .expire_o (expire)
  );

  fsp_decider #(.DW(DW), .POLL_B(POLL_B), .TOGG_B(TOGG_B)) i_decider (
    .data_i      (rd_data_i),
    .exp_i       (exp_q),
    .erase_i     (erase_q),
    .toggle_i    (toggle_q),
    .prev_vld_i  (prev_vld_q),
    .prev_bit_i  (prev_bit_q),
    .poll_done_o (poll_done),
    .diff_o      (diff)
  );

  always_comb begin
    state_d  = state_q;
    finish   = 1'b0;
    set_mis  = 1'b0;
    upd_prev = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_REQ;
      ST_REQ:   state_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_valid_i) begin
          if (poll_done && toggle_q) begin
            finish = 1'b1;
          end else if (poll_done) begin
            state_d = ST_VREQ;
          end else begin
            upd_prev = 1'b1;
            state_d  = ST_REQ;
          end
        end
      end
      ST_VREQ:  state_d = ST_VWAIT;
      ST_VWAIT: begin
        if (rd_valid_i) begin
          finish  = 1'b1;
          set_mis = diff;
        end
      end
      default:  state_d = ST_IDLE;
    endcase
    // completion beats an expiring limit in the same cycle
    abort = expire && !finish;
    if (finish || abort) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      exp_q      <= '0;
      lim_q      <= '0;
      erase_q    <= 1'b0;
      toggle_q   <= 1'b0;
      prev_vld_q <= 1'b0;
      prev_bit_q <= 1'b0;
      done_q     <= 1'b0;
      to_q       <= 1'b0;
      mis_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (accept) begin
        exp_q      <= exp_data_i;
        lim_q      <= timeout_cycles_i;
        erase_q    <= op_erase_i;
        toggle_q   <= mode_toggle_i;
        prev_vld_q <= 1'b0;
        to_q       <= 1'b0;
        mis_q      <= 1'b0;
      end else begin
        if (upd_prev) begin
          prev_vld_q <= 1'b1;
          prev_bit_q <= rd_data_i[TOGG_B];
        end
        if (abort)   to_q  <= 1'b1;
        if (set_mis) mis_q <= 1'b1;
      end
    end
  end

  assign rd_req_o   = (state_q == ST_REQ) || (state_q == ST_VREQ);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign timeout_o  = to_q;
  assign mismatch_o = mis_q;
endmodule

// File: rtl/fsp_chk.sv
module fsp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic rd_req_o,
  input logic rd_valid_i,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o
);
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    out_q <= 1'b0;
    else if (rd_req_o)              out_q <= 1'b1;
    else if (rd_valid_i || !busy_o) out_q <= 1'b0;
  end

  // R2
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o);
  // R2
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R3
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  // R3
  one_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !out_q);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R9
  to_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (!done_o && !busy_o));
endmodule

bind flash_status_poller fsp_chk i_fsp_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .rd_req_o   (rd_req_o),
  .rd_valid_i (rd_valid_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .timeout_o  (timeout_o)
);

// File: tb/test_flash_status_poller.sv
`timescale 1ns/1ps
module test_flash_status_poller;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        op_erase_i = 1'b0;
  logic        mode_toggle_i = 1'b0;
  logic [7:0]  exp_data_i = '0;
  logic [15:0] timeout_cycles_i = '0;
  logic        rd_req_o;
  logic        rd_valid_i = 1'b0;
  logic [7:0]  rd_data_i = '0;
  logic        busy_o, done_o, timeout_o, mismatch_o;

  int checks = 0;
  int failures = 0;

  logic [7:0] resp [16];
  int  resp_n;
  bit  alt_mode;

  int  r_reads, r_busy;
  bit  r_done, r_to, r_mis, r_first_ok, r_clear_ok, r_done_idle, r_done_low;

  flash_status_poller i_flash_status_poller (.*);

  always #2.5 clk_i = ~clk_i;

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pick(input int i);
    if (alt_mode) return i[0] ? 8'h40 : 8'h00;
    return resp[(i < resp_n) ? i : resp_n - 1];
  endfunction

  task automatic run_op(input bit erase, input bit tog, input logic [7:0] exp,
                        input logic [15:0] lim, input int lat, input int inj);
    int  pend;
    bit  fin;
    @(negedge clk_i);
    start_i = 1'b1; op_erase_i = erase; mode_toggle_i = tog;
    exp_data_i = exp; timeout_cycles_i = lim;
    @(negedge clk_i);
    start_i = 1'b0;
    r_first_ok = busy_o && rd_req_o;
    r_clear_ok = !timeout_o && !mismatch_o;
    pend = -1; fin = 0;
    r_reads = 0; r_busy = 0; r_done = 0; r_to = 0; r_mis = 0; r_done_idle = 0;
    for (int c = 0; c < 5000 && !fin; c++) begin
      rd_valid_i = 1'b0;
      start_i    = 1'b0;
      if (done_o) begin
        r_done = 1; r_mis = mismatch_o; r_done_idle = !busy_o; r_to = timeout_o; fin = 1;
      end else if (!busy_o) begin
        r_to = timeout_o; fin = 1;
      end else begin
        r_busy++;
        if (c == inj) begin
          start_i = 1'b1; exp_data_i = ~exp; op_erase_i = ~erase; mode_toggle_i = ~tog;
        end
        if (pend > 0) begin
          pend--;
          if (pend == 0) begin
            rd_valid_i = 1'b1; rd_data_i = pick(r_reads); r_reads++;
          end
        end
        if (rd_req_o) pend = lat;
      end
      if (!fin) @(negedge clk_i);
    end
    start_i = 1'b0; rd_valid_i = 1'b0;
    r_done_low = 1;
    if (r_done) begin
      @(negedge clk_i);
      r_done_low = !done_o;
    end
  endtask

  task automatic t_reset;
    chk(!busy_o && !rd_req_o && !done_o && !timeout_o && !mismatch_o, "R1 reset outputs",
        {busy_o, rd_req_o, done_o, timeout_o, mismatch_o}, 0);
  endtask

  task automatic t_program_ok;
    alt_mode = 0; resp_n = 4;
    resp[0] = 8'h25; resp[1] = 8'h25; resp[2] = 8'hA5; resp[3] = 8'hA5;
    run_op(0, 0, 8'hA5, 16'd0, 2, -1);
    chk(r_first_ok, "R2 busy and first request after start", r_first_ok, 1);
    chk(r_reads == 4, "R4 program read count", r_reads, 4);
    chk(r_busy == 12, "R3 back-to-back request spacing", r_busy, 12);
    chk(r_done && !r_mis, "R6 verify match", r_mis, 0);
    chk(r_done_idle && r_done_low, "R8 done single pulse idle", {r_done_idle, r_done_low}, 3);
  endtask

  task automatic t_program_mis;
    alt_mode = 0; resp_n = 3;
    resp[0] = 8'hDA; resp[1] = 8'h1A; resp[2] = 8'h1A;
    run_op(0, 0, 8'h5A, 16'd0, 1, -1);
    chk(r_reads == 3, "R4 program bit7 low complete count", r_reads, 3);
    chk(r_done && r_mis, "R6 verify mismatch flagged", r_mis, 1);
  endtask

  task automatic t_erase;
    alt_mode = 0; resp_n = 4;
    resp[0] = 8'h00; resp[1] = 8'h00; resp[2] = 8'h80; resp[3] = 8'h00;
    run_op(1, 0, 8'h00, 16'd0, 1, -1);
    chk(r_clear_ok, "R12 mismatch cleared by start", r_clear_ok, 1);
    chk(r_reads == 4, "R5 erase ignores expected bit7", r_reads, 4);
    chk(r_done && !r_mis, "R5 erase verify", r_mis, 0);
  endtask

  task automatic t_toggle;
    alt_mode = 0; resp_n = 4;
    resp[0] = 8'h40; resp[1] = 8'h00; resp[2] = 8'h40; resp[3] = 8'h40;
    run_op(0, 1, 8'h12, 16'd0, 1, -1);
    chk(r_reads == 4, "R7 toggle settles on equal pair", r_reads, 4);
    chk(r_done && !r_mis, "R7 toggle no mismatch", r_mis, 0);
    resp_n = 2; resp[0] = 8'h00; resp[1] = 8'h00;
    run_op(1, 1, 8'hFF, 16'd0, 1, -1);
    chk(r_reads == 2, "R7 first read never completes", r_reads, 2);
  endtask

  task automatic t_timeout;
    alt_mode = 1;
    run_op(0, 1, 8'h00, 16'd20, 1, -1);
    chk(r_to && !r_done, "R9 timeout flagged no done", {r_to, r_done}, 2);
    chk(r_busy == 20, "R9 busy cycles at timeout", r_busy, 20);
    alt_mode = 0; resp_n = 2; resp[0] = 8'h00; resp[1] = 8'h00;
    run_op(0, 1, 8'h00, 16'd0, 1, -1);
    chk(r_clear_ok, "R12 timeout cleared by start", r_clear_ok, 1);
  endtask

  task automatic t_no_limit;
    alt_mode = 0; resp_n = 11;
    for (int i = 0; i < 11; i++) resp[i] = i[0] ? 8'h40 : 8'h00;
    resp[10] = 8'h40;
    run_op(0, 1, 8'h00, 16'd0, 1, -1);
    chk(r_done && !r_to && r_reads == 11, "R9 zero limit disables", r_reads, 11);
  endtask

  task automatic t_tie;
    alt_mode = 0; resp_n = 2; resp[0] = 8'h00; resp[1] = 8'h00;
    run_op(0, 1, 8'h00, 16'd4, 1, -1);
    chk(r_done && !r_to, "R11 completion wins same cycle", {r_done, r_to}, 2);
    chk(r_busy == 4, "R11 busy length on tie", r_busy, 4);
    run_op(0, 1, 8'h00, 16'd3, 1, -1);
    chk(r_to && !r_done && r_busy == 3, "R9 one cycle short times out", r_busy, 3);
  endtask

  task automatic t_ignore_start;
    alt_mode = 0; resp_n = 4;
    resp[0] = 8'h25; resp[1] = 8'h25; resp[2] = 8'hA5; resp[3] = 8'hA5;
    run_op(0, 0, 8'hA5, 16'd0, 2, 2);
    chk(r_reads == 4 && r_busy == 12, "R10 busy start ignored count", r_reads, 4);
    chk(r_done && !r_mis, "R10 latched expected byte kept", r_mis, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_program_ok();
    t_program_mis();
    t_erase();
    t_toggle();
    t_timeout();
    t_no_limit();
    t_tie();
    t_ignore_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule